// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Read Master

This block fetches 16-bit words from a serial EEPROM. The EEPROM sits on four pins: a chip select, a shift clock, a serial line toward the memory and a serial line back from it. When the block gets a start request, it frames a read command. The command holds leading zeros, a start bit, a two-bit read opcode and the word address, and is sent most significant bit first. The block then shifts in sixteen data bits and hands the word back with a one-cycle done pulse. The address field is 6 or 8 bits wide. The host picks the width with a configuration input. Each half-period of the serial clock lasts a programmable number of system clocks.

After reset, an auto-load sequencer takes the read engine for itself.

1. It reads word 0 with an 8-bit address and compares the result against a signature. The result sets the address width.
2. It then reads words 7, 8 and 9 and packs them into a 48-bit station address, with the low byte of each word placed first.

Host requests are locked out until auto-load completes. After that the station address and its valid flag stay put until the next reset.

Top module: `eeprom_rd_top`

## Requirements
- R1: While reset is held, ee_cs_o, ee_sk_o, ee_di_o, done_o and station_vld_o are 0. In the first cycle after reset, busy_o is 1 because auto-load is running.
- R2: A read sends AW+5 serial clock rising edges of command, where AW is 8 if the width select is 1 and 6 if it is 0. The command is binary 110 shifted left by AW and ORed with the address, sent MSB first, so its two top bits are 0. The data line is set while the clock is low and held while it is high.
- R3: After the command, the block reads sixteen data bits MSB first. Each bit is sampled at the end of a clock-high half-period. The word appears on data_o.
- R4: Chip select stays low for the first half-period after an accepted start. It is high from the next half-period through the last data bit, and is low again for a final half-period before done. The clock is never high while chip select is low.
- R5: A half-period lasts max(half_cfg_i, 4) system clocks. The value is captured when the start is accepted and later changes have no effect. A read takes (2*AW+46) half-periods from the accepting edge to the edge that raises done_o.
- R6: busy_o rises in the cycle after an accepted start. done_o is a one-cycle pulse in the first cycle busy_o is low. data_o holds the word until the next done.
- R7: A start request while busy_o is high is ignored. The current read's address and result are unchanged, and no further transfer follows it.
- R8: With the width select at 0, only the low 6 address bits are sent and the upper two are ignored.
- R9: Auto-load reads word 0 with an 8-bit address. If the result is 0x8129, wide_det_o becomes 1 and later auto-load reads use 8-bit addresses. Otherwise it becomes 0 and they use 6-bit addresses. The flag holds once auto-load ends.
- R10: station_o is 0 until auto-load ends. Then station_o[15:0] = word 7, [31:16] = word 8 and [47:32] = word 9, so station_o[7:0] is the first address byte. station_vld_o rises and stays high with station_o unchanged.
- R11: During auto-load, host starts are ignored and done_o does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_cfg_i | input | HALF_W | Serial clock half-period in system clocks (minimum 4) |
| start_i | input | 1 | Read request |
| addr_i | input | 8 | Word address |
| wide_i | input | 1 | Address width select: 1 = 8 bits, 0 = 6 bits |
| busy_o | output | 1 | Read or auto-load in progress |
| done_o | output | 1 | One-cycle pulse when a host read completes |
| data_o | output | DATA_W | Last word read |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM shift clock |
| ee_di_o | output | 1 | Serial data toward the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| station_o | output | 3*DATA_W | Auto-loaded station address |
| station_vld_o | output | 1 | Station address loaded |
| wide_det_o | output | 1 | Detected 8-bit address width |

## Verification
The bench builds the block with DATA_W=16 and HALF_W=4. With a 4-bit half-period field, the values below the minimum of 4 (which must be clamped) and larger settings up to 15 can all be driven, and every read stays a few hundred cycles long. The bench models a 6-bit and an 8-bit EEPROM in turn. The 6-bit device garbles the 8-bit probe of word 0, so both outcomes of width detection are reached.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  localparam int unsigned NARROW_AW = 6;
  localparam int unsigned WIDE_AW   = 8;
  // two leading zeros, start bit, two opcode bits
  localparam int unsigned CMD_PAD   = 5;
  localparam logic [2:0]  READ_OP   = 3'b110;
  localparam int unsigned MIN_HALF  = 4;
  localparam logic [15:0] WIDE_SIG  = 16'h8129;
  localparam int unsigned STN_BASE  = 7;
  localparam int unsigned STN_WORDS = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_SEL, ST_CMD_LO, ST_CMD_HI,
    ST_GAP, ST_DAT_HI, ST_DAT_LO, ST_POST
  } eng_st_e;

  typedef enum logic [1:0] {AL_ISSUE, AL_WAIT, AL_FIN} al_st_e;
endpackage

// File: rtl/eeprom_half_timer.sv
module eeprom_half_timer #(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + HALF_W'(1);
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half_i));
endmodule

// File: rtl/eeprom_rd_engine.sv
module eeprom_rd_engine
  import eeprom_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned HALF_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HALF_W-1:0]  half_i,
  input  logic               start_i,
  input  logic [WIDE_AW-1:0] addr_i,
  input  logic               wide_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               cs_o,
  output logic               sk_o,
  output logic               di_o,
  input  logic               do_i
);
  localparam int unsigned CMD_W    = WIDE_AW + CMD_PAD;
  localparam int unsigned IDX_W    = $clog2((CMD_W > DATA_W) ? CMD_W : DATA_W);
  localparam int unsigned CMD_SPAN = 1 << IDX_W;

  eng_st_e st_q, st_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [CMD_SPAN-1:0] cmd_q, cmd_new;
  logic [HALF_W-1:0]   half_q, half_eff;
  logic [DATA_W-1:0]   shf_q, rd_q;
  logic [1:0]          do_sync_q;
  logic tick, accept, run, done_q, cs_q, sk_q, di_q;

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign run      = (st_q != ST_IDLE);
  assign half_eff = (half_i < HALF_W'(MIN_HALF)) ? HALF_W'(MIN_HALF) : half_i;

  always_comb begin
    if (wide_i) cmd_new = (CMD_SPAN'(READ_OP) << WIDE_AW) | CMD_SPAN'(addr_i);
    else        cmd_new = (CMD_SPAN'(READ_OP) << NARROW_AW) | CMD_SPAN'(addr_i[NARROW_AW-1:0]);
  end

  eeprom_half_timer #(.HALF_W(HALF_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .half_i (half_q),
    .tick_o (tick)
  );

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (accept) begin
      st_d  = ST_PRE;
      idx_d = wide_i ? IDX_W'(WIDE_AW + CMD_PAD - 1) : IDX_W'(NARROW_AW + CMD_PAD - 1);
    end else if (tick) begin
      case (st_q)
        ST_PRE:    st_d = ST_SEL;
        ST_SEL:    st_d = ST_CMD_LO;
        ST_CMD_LO: st_d = ST_CMD_HI;
        ST_CMD_HI: begin
          if (idx_q == '0) st_d = ST_GAP;
          else begin
            st_d  = ST_CMD_LO;
            idx_d = idx_q - IDX_W'(1);
          end
        end
        ST_GAP: begin
          st_d  = ST_DAT_HI;
          idx_d = IDX_W'(DATA_W - 1);
        end
        ST_DAT_HI: st_d = ST_DAT_LO;
        ST_DAT_LO: begin
          if (idx_q == '0) st_d = ST_POST;
          else begin
            st_d  = ST_DAT_HI;
            idx_d = idx_q - IDX_W'(1);
          end
        end
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      cmd_q     <= '0;
      half_q    <= HALF_W'(MIN_HALF);
      shf_q     <= '0;
      rd_q      <= '0;
      done_q    <= 1'b0;
      cs_q      <= 1'b0;
      sk_q      <= 1'b0;
      di_q      <= 1'b0;
      do_sync_q <= '0;
    end else begin
      st_q      <= st_d;
      idx_q     <= idx_d;
      do_sync_q <= {do_sync_q[0], do_i};
      if (accept) begin
        cmd_q  <= cmd_new;
        half_q <= half_eff;
      end
      if (tick && st_q == ST_DAT_HI) shf_q <= {shf_q[DATA_W-2:0], do_sync_q[1]};
      if (tick && st_q == ST_POST)   rd_q  <= shf_q;
      done_q <= tick && (st_q == ST_POST);
      // pins follow the next state so they change on one edge, glitch free
      cs_q <= !(st_d inside {ST_IDLE, ST_PRE, ST_POST});
      sk_q <= st_d inside {ST_CMD_HI, ST_DAT_HI};
      di_q <= (st_d inside {ST_CMD_LO, ST_CMD_HI}) && cmd_q[idx_d];
    end
  end

  assign busy_o = run;
  assign done_o = done_q;
  assign data_o = rd_q;
  assign cs_o   = cs_q;
  assign sk_o   = sk_q;
  assign di_o   = di_q;

  // R4
  sk_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);
  // R2
  di_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && $past(sk_o)) |-> $stable(di_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R7
  ign_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(cmd_q));
endmodule

// File: rtl/eeprom_autoload.sv
module eeprom_autoload
  import eeprom_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          eng_done_i,
  input  logic [DATA_W-1:0]             eng_data_i,
  output logic                          req_o,
  output logic [WIDE_AW-1:0]            addr_o,
  output logic                          wide_o,
  output logic                          active_o,
  output logic                          wide_det_o,
  output logic [STN_WORDS*DATA_W-1:0]   station_o,
  output logic                          station_vld_o
);
  localparam int unsigned CNT_W = $clog2(STN_WORDS + 1);

  al_st_e            st_q;
  logic [CNT_W-1:0]  idx_q;
  logic              wide_q, vld_q;
  logic [DATA_W-1:0] words_q [STN_WORDS];

  assign req_o    = (st_q == AL_ISSUE);
  assign active_o = (st_q != AL_FIN);
  // idx 0 is the width probe, then the station words
  assign addr_o   = (idx_q == '0) ? '0
                  : WIDE_AW'(STN_BASE) + WIDE_AW'(idx_q) - WIDE_AW'(1);
  assign wide_o   = (idx_q == '0) ? 1'b1 : wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= AL_ISSUE;
      idx_q  <= '0;
      wide_q <= 1'b0;
      vld_q  <= 1'b0;
      for (int i = 0; i < STN_WORDS; i++) words_q[i] <= '0;
    end else begin
      case (st_q)
        AL_ISSUE: st_q <= AL_WAIT;
        AL_WAIT: if (eng_done_i) begin
          if (idx_q == '0) wide_q <= (eng_data_i == DATA_W'(WIDE_SIG));
          else             words_q[idx_q - CNT_W'(1)] <= eng_data_i;
          idx_q <= idx_q + CNT_W'(1);
          if (idx_q == CNT_W'(STN_WORDS)) begin
            st_q  <= AL_FIN;
            vld_q <= 1'b1;
          end else begin
            st_q  <= AL_ISSUE;
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < STN_WORDS; g++) begin : g_stn
    assign station_o[g*DATA_W +: DATA_W] = vld_q ? words_q[g] : '0;
  end

  assign wide_det_o    = wide_q;
  assign station_vld_o = vld_q;

  // R10
  vld_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    station_vld_o |=> (station_vld_o && $stable(station_o)));
  // R9
  det_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |=> $stable(wide_det_o));
endmodule

// File: rtl/eeprom_rd_top.sv
module eeprom_rd_top
  import eeprom_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned HALF_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [HALF_W-1:0]           half_cfg_i,
  input  logic                        start_i,
  input  logic [WIDE_AW-1:0]          addr_i,
  input  logic                        wide_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [DATA_W-1:0]           data_o,
  output logic                        ee_cs_o,
  output logic                        ee_sk_o,
  output logic                        ee_di_o,
  input  logic                        ee_do_i,
  output logic [STN_WORDS*DATA_W-1:0] station_o,
  output logic                        station_vld_o,
  output logic                        wide_det_o
);
  logic               al_req, al_wide, al_active;
  logic [WIDE_AW-1:0] al_addr;
  logic               eng_start, eng_wide, eng_busy, eng_done;
  logic [WIDE_AW-1:0] eng_addr;
  logic [DATA_W-1:0]  eng_data;

  // auto-load owns the engine until it finishes
  assign eng_start = al_active ? al_req  : start_i;
  assign eng_addr  = al_active ? al_addr : addr_i;
  assign eng_wide  = al_active ? al_wide : wide_i;

  eeprom_rd_engine #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .half_i  (half_cfg_i),
    .start_i (eng_start),
    .addr_i  (eng_addr),
    .wide_i  (eng_wide),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .data_o  (eng_data),
    .cs_o    (ee_cs_o),
    .sk_o    (ee_sk_o),
    .di_o    (ee_di_o),
    .do_i    (ee_do_i)
  );

  eeprom_autoload #(.DATA_W(DATA_W)) u_al (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .eng_done_i    (eng_done),
    .eng_data_i    (eng_data),
    .req_o         (al_req),
    .addr_o        (al_addr),
    .wide_o        (al_wide),
    .active_o      (al_active),
    .wide_det_o    (wide_det_o),
    .station_o     (station_o),
    .station_vld_o (station_vld_o)
  );

  assign busy_o = eng_busy | al_active;
  assign done_o = eng_done & ~al_active;
  assign data_o = eng_data;
endmodule

// File: tb/eeprom_rd_top_tb_top.sv
module eeprom_rd_top_tb_top;
  localparam int DW = 16;
  localparam int HW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HW-1:0] half = 4'd4;
  logic start = 1'b0, wide = 1'b0;
  logic [7:0] addr = '0;
  logic busy, done, cs, sk, di, vld, wdet;
  logic [DW-1:0] data;
  logic [3*DW-1:0] stn;
  logic m_do = 1'b0;

  eeprom_rd_top #(.DATA_W(DW), .HALF_W(HW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .half_cfg_i(half), .start_i(start),
    .addr_i(addr), .wide_i(wide), .busy_o(busy), .done_o(done), .data_o(data),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(m_do),
    .station_o(stn), .station_vld_o(vld), .wide_det_o(wdet)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // EEPROM model
  int dev_aw = 8;
  logic [15:0] sig = 16'h8129;
  int m_ph = 0, m_k = 0;
  logic [1:0] m_op = '0;
  logic [7:0] m_addr = '0;
  logic [15:0] m_word = '0;

  function automatic logic [15:0] mem(input logic [7:0] a);
    if (a == 8'h00) return sig;
    return 16'h3C5A ^ ({8'h00, a} * 16'd257) ^ 16'h0100;
  endfunction

  always @(posedge cs) begin
    m_ph = 0;
    m_do = 1'b0;
  end

  always @(posedge sk) if (cs) begin
    case (m_ph)
      0: if (di) begin m_ph = 1; m_k = 0; m_op = '0; m_addr = '0; end
      1: begin
        m_op = {m_op[0], di}; m_k++;
        if (m_k == 2) begin m_ph = 2; m_k = 0; end
      end
      2: begin
        m_addr = {m_addr[6:0], di}; m_k++;
        if (m_k == dev_aw) begin m_ph = 3; m_k = 15; m_word = mem(m_addr); end
      end
      3: begin
        m_do = m_word[m_k];
        if (m_k == 0) m_ph = 4; else m_k--;
      end
      default: m_do = 1'b0;
    endcase
  end

  // serial clock monitors
  int sk_cnt = 0, sk_hi = 0, n_done = 0;
  time t_rise = 0;
  always @(posedge cs) sk_cnt = 0;
  always @(posedge sk) begin sk_cnt++; t_rise = $time; end
  always @(negedge sk) sk_hi = int'(($time - t_rise) / 10);
  always @(posedge clk) if (rst_n && done) n_done++;

  task automatic do_reset(input int aw, input logic [15:0] s);
    dev_aw = aw; sig = s;
    rst_n = 1'b0; start = 1'b0; half = 4'd4; addr = '0; wide = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "cs in reset", cs, 0);
    check("R1", "sk in reset", sk, 0);
    check("R1", "di in reset", di, 0);
    check("R1", "done/vld in reset", {done, vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", busy, 1);
    n_done = 0;
  endtask

  task automatic t_autoload(input bit exp_w, input bit poke);
    int n = 0;
    if (poke) begin
      repeat (40) @(negedge clk);
      addr = 8'h55; wide = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    check("R10", "station before load", {vld, stn}, 0);
    while (!vld && n < 20000) begin @(negedge clk); n++; end
    check("R9", "width detect", wdet, exp_w);
    check("R10", "station words", stn, {mem(8'd9), mem(8'd8), mem(8'd7)});
    check("R10", "first byte", stn[7:0], mem(8'd7) & 16'h00FF);
    check("R11", "no host done during load", n_done, 0);
    repeat (20) @(negedge clk);
    check("R11", "host start ignored during load", {busy, cs, n_done[3:0]}, 0);
  endtask

  task automatic t_read(input logic [7:0] a, input bit w, input int h, input int h_late);
    int aw = w ? 8 : 6;
    int heff = (h < 4) ? 4 : h;
    int c0;
    logic [7:0] ea = w ? a : {2'b00, a[5:0]};
    @(negedge clk);
    half = HW'(h); addr = a; wide = w; start = 1'b1; c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    check("R6", "busy after start", busy, 1);
    check("R4", "cs low first half", cs, 0);
    if (h_late >= 0) half = HW'(h_late);
    while (!done && (cyc - c0) < 5000) @(negedge clk);
    check("R5", "read duration", cyc - c0, (2 * aw + 46) * heff + 1);
    check("R3", "data word", data, mem(ea));
    check("R2", "opcode", m_op, 2'b10);
    check(w ? "R2" : "R8", "address seen", m_addr, ea);
    check("R2", "clock edges", sk_cnt, aw + 5 + 16);
    check("R5", "sk high width", sk_hi, heff);
    check("R4", "cs low at done", {cs, busy}, 0);
    @(negedge clk);
    check("R6", "done single", done, 0);
    check("R6", "data held", data, mem(ea));
  endtask

  task automatic t_ignore();
    @(negedge clk);
    half = 4'd4; addr = 8'h03; wide = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    addr = 8'h44; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R7", "data unchanged", data, mem(8'h03));
    check("R7", "address unchanged", m_addr, 8'h03);
    repeat (30) @(negedge clk);
    check("R7", "no second transfer", {busy, cs}, 0);
    check("R6", "data still held", data, mem(8'h03));
  endtask

  initial begin
    do_reset(8, 16'h8129);
    t_autoload(1'b1, 1'b1);
    t_read(8'h00, 1'b1, 4, -1);
    t_read(8'hA7, 1'b1, 5, -1);
    t_read(8'hFF, 1'b1, 4, -1);
    t_read(8'h12, 1'b1, 2, 9);   // clamp and late change
    t_ignore();
    do_reset(6, 16'h1234);
    t_autoload(1'b0, 1'b0);
    t_read(8'hE5, 1'b0, 4, -1);  // upper bits dropped
    t_read(8'h3F, 1'b0, 6, -1);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule